// File: doc/BRIEF.md
# Board Self-Test Mode Controller

This block is a built-in diagnostic engine for a small board that carries two 8-bit slide-switch banks, eight push buttons that share their pins with eight LEDs, and two seven-segment displays. After an internal power-on reset it runs one of three tests, chosen by the lowest switch of each bank. The first test shows a free-running 8-bit counter as two hex digits and rotates whatever pattern the LEDs last held. The second test echoes switch bits straight onto segments and, when both displays form valid hex glyphs, shows their 4-bit values on interleaved LEDs. The third test echoes button presses onto segments and releases the shared LED pins so the buttons can be read.

The block drives two 7-bit segment patterns, the 8-bit LED value and an output-enable for the shared LED/button pins. Strobing of the display latches and the pad tristate sit outside the block. All switch and button inputs read 0 when a switch is on or a button is pressed; all segments and LEDs light on 0. Segment vectors use bit 0 for segment a up to bit 6 for segment g.

Top module: `selftest_ctrl`

## Requirements
- R1: There is no reset input. For the first 8 clock edges after start-up the block is in power-on reset: both segment outputs are 7'h7F (dark), `led_out` is 8'hFF and `led_oe` is 0. The selected test takes effect from the 9th edge.
- R2: The mode is taken from `sw_a[0]` and `sw_b[0]`: `sw_a[0]`=1 selects the counter test whatever `sw_b[0]` is; `sw_a[0]`=0 with `sw_b[0]`=1 selects the switch test; both 0 selects the button test.
- R3: An 8-bit counter is cleared by the power-on reset and advances by one on every edge after it, in all modes. In the counter test the output sampled after edge e (e counted from 1) shows the count e-9 modulo 256: high nibble on `seg_a`, low nibble on `seg_b`. Each nibble uses the active-low glyph for 0-9, A, b, C, d, E, F (active-high gfedcba codes 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71).
- R4: In the counter test `led_oe` is 1 and `led_out` rotates left by one place on every edge, starting from the value it held before (bit 7 moves into bit 0).
- R5: In the switch test `seg_a[k]` equals `sw_a[k+1]` and `seg_b[k]` equals `sw_b[k+1]` for k = 0..6; bit 0 of each bank drives no segment.
- R6: In the switch test, when both segment patterns match glyphs from R3 with values VA and VB, `led_out` bits 7,5,3,1 carry the inverse of VA bits 3,2,1,0 and bits 6,4,2,0 carry the inverse of VB bits 3,2,1,0 (a 1 in the value lights its LED); otherwise `led_out` is 8'h00 (all lit). `led_oe` is 1.
- R7: In the button test `led_oe` is 0, `seg_a` bits e,d,b,a (4,3,1,0) follow `pad_in` bits 7,5,3,1, `seg_b` bits e,d,b,a follow `pad_in` bits 6,4,2,0, and segments c, f, g stay dark.
- R8: In the button test the LED register is loaded with 8'h88, so a later counter test rotates 8'h88 (first 8'h11, then 8'h22).
- R9: Every output is registered: a change at the inputs shows on the outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| sw_a | input | 8 | Switch bank A, 0 = switch on; bit 0 is a mode select |
| sw_b | input | 8 | Switch bank B, 0 = switch on; bit 0 is a mode select |
| pad_in | input | 8 | Read-back of the shared LED/button pins, 0 = pressed |
| seg_a | output | 7 | Display A segments, bit 0 = a, 0 = lit |
| seg_b | output | 7 | Display B segments, bit 0 = a, 0 = lit |
| led_out | output | 8 | LED drive value, 0 = lit |
| led_oe | output | 1 | Output-enable for the shared LED/button pins |

## Verification
The counter test is watched for several hundred consecutive edges against a count derived from the edge number, under both settings of `sw_b[0]`, and again after time spent in other modes, which separates a free-running counter from one that pauses or restarts. The switch test sweeps all 128 patterns of each bank while the other bank holds a valid glyph, so every glyph is told apart from every near-miss and each LED bit is tied to the right nibble bit. The button test sweeps all 256 button patterns, which exposes swapped or missing segment links, and the returns to the counter test check that the LED rotation starts from the value the previous test left, 8'h88 or the decoded switch value.

// File: rtl/selftest_ctrl.sv
module selftest_ctrl #(
  parameter int POR_CYCLES = 8,
  parameter logic [7:0] BTN_LED_INIT = 8'h88
) (
  input  logic       clk,
  input  logic [7:0] sw_a,
  input  logic [7:0] sw_b,
  input  logic [7:0] pad_in,
  output logic [6:0] seg_a,
  output logic [6:0] seg_b,
  output logic [7:0] led_out,
  output logic       led_oe
);

  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam logic [6:0] DARK = 7'h7F;

  typedef enum logic [1:0] {M_CNT, M_SW, M_BTN} mode_t;

  logic [PW-1:0] por_cnt = '0;
  logic          por_busy;
  logic [7:0]    cnt = '0;
  logic [6:0]    seg_a_q = DARK;
  logic [6:0]    seg_b_q = DARK;
  logic [7:0]    led_q = 8'hFF;
  logic          oe_q = 1'b0;
  mode_t         mode;

  function automatic logic [6:0] glyph(input logic [3:0] v);
    logic [6:0] on;
    case (v)
      4'h0: on = 7'h3F; 4'h1: on = 7'h06; 4'h2: on = 7'h5B; 4'h3: on = 7'h4F;
      4'h4: on = 7'h66; 4'h5: on = 7'h6D; 4'h6: on = 7'h7D; 4'h7: on = 7'h07;
      4'h8: on = 7'h7F; 4'h9: on = 7'h6F; 4'hA: on = 7'h77; 4'hB: on = 7'h7C;
      4'hC: on = 7'h39; 4'hD: on = 7'h5E; 4'hE: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  function automatic logic [4:0] unglyph(input logic [6:0] s);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 16; i++)
      if (glyph(4'(i)) == s) r = {1'b1, 4'(i)};
    return r;
  endfunction

  assign por_busy = (por_cnt != PW'(POR_CYCLES));

  always_comb begin
    if (sw_a[0])      mode = M_CNT;
    else if (sw_b[0]) mode = M_SW;
    else              mode = M_BTN;
  end

  logic [4:0] dec_a, dec_b;
  logic [7:0] sw_led;
  assign dec_a = unglyph(sw_a[7:1]);
  assign dec_b = unglyph(sw_b[7:1]);

  always_comb begin
    if (dec_a[4] && dec_b[4])
      sw_led = ~{dec_a[3], dec_b[3], dec_a[2], dec_b[2],
                 dec_a[1], dec_b[1], dec_a[0], dec_b[0]};
    else
      sw_led = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (por_busy) begin
      por_cnt <= por_cnt + 1'b1;
      cnt     <= '0;
      seg_a_q <= DARK;
      seg_b_q <= DARK;
      led_q   <= 8'hFF;
      oe_q    <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      case (mode)
        M_CNT: begin
          seg_a_q <= glyph(cnt[7:4]);
          seg_b_q <= glyph(cnt[3:0]);
          led_q   <= {led_q[6:0], led_q[7]};
          oe_q    <= 1'b1;
        end
        M_SW: begin
          seg_a_q <= sw_a[7:1];
          seg_b_q <= sw_b[7:1];
          led_q   <= sw_led;
          oe_q    <= 1'b1;
        end
        default: begin
          seg_a_q <= {2'b11, pad_in[7], pad_in[5], 1'b1, pad_in[3], pad_in[1]};
          seg_b_q <= {2'b11, pad_in[6], pad_in[4], 1'b1, pad_in[2], pad_in[0]};
          led_q   <= BTN_LED_INIT;
          oe_q    <= 1'b0;
        end
      endcase
    end
  end

  assign seg_a   = seg_a_q;
  assign seg_b   = seg_b_q;
  assign led_out = led_q;
  assign led_oe  = oe_q;

endmodule

// File: rtl/selftest_ctrl_chk.sv
module selftest_ctrl_chk (
  input logic       clk,
  input logic       por_busy,
  input logic [7:0] sw_a,
  input logic [7:0] sw_b,
  input logic [7:0] pad_in,
  input logic [6:0] seg_a,
  input logic [6:0] seg_b,
  input logic [7:0] led_out,
  input logic       led_oe
);

  // R1
  por_oe_off_chk: assert property (@(posedge clk) por_busy |-> !led_oe);

  // R4
  cnt_rotate_chk: assert property (@(posedge clk) disable iff (por_busy)
    sw_a[0] |=> (led_oe && led_out == {$past(led_out[6:0]), $past(led_out[7])}));

  // R5
  sw_echo_chk: assert property (@(posedge clk) disable iff (por_busy)
    (!sw_a[0] && sw_b[0]) |=> (seg_a == $past(sw_a[7:1]) && seg_b == $past(sw_b[7:1])));

  // R7
  btn_seg_chk: assert property (@(posedge clk) disable iff (por_busy)
    (!sw_a[0] && !sw_b[0]) |=> (seg_a[0] == $past(pad_in[1]) && seg_a[4] == $past(pad_in[7])
                                && seg_b[1] == $past(pad_in[2]) && seg_b[6:5] == 2'b11));

  // R8
  btn_led_chk: assert property (@(posedge clk) disable iff (por_busy)
    (!sw_a[0] && !sw_b[0]) |=> (led_out == 8'h88 && !led_oe));

endmodule

bind selftest_ctrl selftest_ctrl_chk u_chk (
  .clk(clk), .por_busy(por_busy), .sw_a(sw_a), .sw_b(sw_b), .pad_in(pad_in),
  .seg_a(seg_a), .seg_b(seg_b), .led_out(led_out), .led_oe(led_oe)
);

// File: tb/test_selftest_ctrl.sv
module test_selftest_ctrl;
  logic       clk = 1'b0;
  logic [7:0] sw_a = 8'hFF, sw_b = 8'hFF, pad_in = 8'hFF;
  logic [6:0] seg_a, seg_b;
  logic [7:0] led_out;
  logic       led_oe;
  int checks = 0, failures = 0, edges = 0;
  bit done = 0;

  selftest_ctrl i_selftest_ctrl (
    .clk(clk), .sw_a(sw_a), .sw_b(sw_b), .pad_in(pad_in),
    .seg_a(seg_a), .seg_b(seg_b), .led_out(led_out), .led_oe(led_oe)
  );

  always #5 clk = ~clk;
  always @(posedge clk) edges++;

  function automatic logic [6:0] gl(input int v);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return ~t[v & 15];
  endfunction

  function automatic int val_of(input logic [6:0] s);
    for (int i = 0; i < 16; i++) if (gl(i) == s) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_counter(input string req);
    int v;
    v = (edges - 9) & 255;
    chk(seg_a == gl(v >> 4), req, seg_a, gl(v >> 4));
    chk(seg_b == gl(v), req, seg_b, gl(v));
    chk(led_oe == 1'b1, "R4 oe", led_oe, 1);
  endtask

  function automatic logic [7:0] sw_leds(input logic [6:0] a, input logic [6:0] b);
    int va, vb;
    va = val_of(a); vb = val_of(b);
    if (va < 0 || vb < 0) return 8'h00;
    return ~{va[3], vb[3], va[2], vb[2], va[1], vb[1], va[0], vb[0]};
  endfunction

  initial begin
    logic [7:0] prev;
    // R1: power-on reset window
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk(seg_a == 7'h7F && seg_b == 7'h7F, "R1 seg dark", {seg_a, seg_b}, 14'h3FFF);
      chk(led_out == 8'hFF && led_oe == 1'b0, "R1 led", {led_oe, led_out}, 9'h0FF);
    end
    // R2 R3 R4: counter test, sw_b[0]=1
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      chk_counter("R3 count");
      chk(led_out == 8'hFF, "R4 rotate FF", led_out, 8'hFF);
    end
    // R2: counter test with sw_b[0]=0
    sw_b = 8'hFE;
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk_counter("R2 a0=1 b0=0 counter");
    end
    // R2 R5 R6: switch test, sweep bank A, bank B holds glyph 3
    sw_a[0] = 1'b0; sw_b = {gl(3), 1'b1};
    for (int i = 0; i < 128; i++) begin
      sw_a = {7'(i), 1'b0};
      @(negedge clk);
      chk(seg_a == 7'(i), "R5 seg_a echo", seg_a, i);
      chk(seg_b == gl(3), "R5 seg_b echo", seg_b, gl(3));
      chk(led_out == sw_leds(7'(i), gl(3)), "R6 glyph leds", led_out, sw_leds(7'(i), gl(3)));
      chk(led_oe == 1'b1, "R2 switch test oe", led_oe, 1);
    end
    sw_a = {gl(10), 1'b0};
    for (int i = 0; i < 128; i++) begin
      sw_b = {7'(i), 1'b1};
      @(negedge clk);
      chk(seg_b == 7'(i), "R5 seg_b echo", seg_b, i);
      chk(led_out == sw_leds(gl(10), 7'(i)), "R6 glyph leds", led_out, sw_leds(gl(10), 7'(i)));
    end
    // R9 R4: switch value 9/C then counter rotates it
    sw_a = {gl(9), 1'b0}; sw_b = {gl(12), 1'b1};
    @(negedge clk);
    prev = sw_leds(gl(9), gl(12));
    chk(led_out == prev, "R6 9C leds", led_out, prev);
    sw_a[0] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      prev = {prev[6:0], prev[7]};
      chk(led_out == prev, "R4 rotate after switch test", led_out, prev);
      chk_counter("R3 count kept running");
    end
    // R7 R8: button test sweep
    sw_a = 8'hFE; sw_b = 8'hFE;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p;
      p = 8'(i);
      pad_in = p;
      @(negedge clk);
      chk(seg_a == {2'b11, p[7], p[5], 1'b1, p[3], p[1]}, "R7 seg_a", seg_a, {2'b11, p[7], p[5], 1'b1, p[3], p[1]});
      chk(seg_b == {2'b11, p[6], p[4], 1'b1, p[2], p[0]}, "R7 seg_b", seg_b, {2'b11, p[6], p[4], 1'b1, p[2], p[0]});
      chk(led_oe == 1'b0, "R7 oe off", led_oe, 0);
      chk(led_out == 8'h88, "R8 led 88", led_out, 8'h88);
    end
    // R9: one-edge latency on mode change
    pad_in = 8'hFF;
    sw_a = 8'hFF;
    #1;
    chk(led_oe == 1'b0, "R9 no change before edge", led_oe, 0);
    prev = 8'h88;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      prev = {prev[6:0], prev[7]};
      chk(led_out == prev, "R8 rotate 88", led_out, prev);
      chk_counter("R3 count after button test");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule